// File: doc/BRIEF.md
# Two-Phase Pre-Scaled FIR Tap Stage

This block is the innermost filter stage of a multidimensional wavelet decomposition engine. It takes two sample streams that together make up one line along the innermost dimension: one carries the samples at even positions (2n), the other the samples at odd positions (2n+1). A pair, one sample from each stream, arrives per accepted transfer. From each pair the stage forms one 1-D filter partial result for one fixed combination of outer coefficient indices.

The filter taps are split by phase. Taps with odd coefficient index are applied to the even-position stream, and taps with even coefficient index are applied to the odd-position stream. The tap for coefficient index 2i+1 or 2i reads its stream delayed by i pairs. Short register chains hold that history. Each tap weight is folded at elaboration time. It is the base coefficient times the constant product of the outer-dimension coefficients that this instance serves. The outer coefficients are chosen by a parity bit per outer dimension. All products feed one adder tree, and the sum is registered.

Both edges use valid/ready. A pair is accepted on a rising clock edge where `in_valid` and `in_ready` are both high. A result leaves on an edge where `out_valid` and `out_ready` are both high. `in_ready` is high whenever the output register is empty or is being emptied in the same cycle. While a result waits with `out_ready` low, the stage accepts nothing, and both the result and the sample history stay frozen.

Top module: `fir2p_tap_stage`

## Requirements
- R1: After reset, `out_valid` is 0 and `in_ready` is 1.
- R2: Tap weight k equals floor(h_k · Π_d h_{p_d} / 2^(FRAC_W·OUTER_DIMS)). Here h is the signed base coefficient list in Q(FRAC_W), and p_d is bit d of `OUTER_PARITY`, a value of 0 or 1 that selects h_0 or h_1. The weight is stored in W_W signed bits.
- R3: For accepted pair number n (counting from 0 after reset), the result is Σ_i w_{2i+1}·even[n−i] + Σ_i w_{2i}·odd[n−i]. It is computed as a signed full-precision sum in OUT_W bits.
- R4: The first ceil(NTAPS/2)−1 accepted pairs after reset produce no result. Every later accepted pair produces exactly one result, and results leave in acceptance order.
- R5: When the output register is free, the result of an accepted pair is presented with `out_valid` high in the cycle right after acceptance.
- R6: `in_ready` = !`out_valid` || `out_ready`. While `out_valid` is high and `out_ready` is low, `out_data` and `out_valid` hold unchanged.
- R7: A cycle without acceptance (in_valid low, or in_ready low) leaves the sample history unchanged. The values on the data inputs in such cycles have no effect on any later result.
- R8: Samples are signed two's complement. Full-scale positive and negative inputs give the exact signed result of R3, without wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A sample pair is offered |
| in_ready | output | 1 | The stage can take a pair this cycle |
| in_even | input | DATA_W | Signed sample at even position 2n |
| in_odd | input | DATA_W | Signed sample at odd position 2n+1 |
| out_valid | output | 1 | `out_data` holds a result |
| out_ready | input | 1 | Downstream takes the result this cycle |
| out_data | output | OUT_W | Signed filter partial result |

## Verification
The assertions place no persistence rule on `in_valid`. A producer may withdraw an offer, and the properties only relate an acceptance to the output register state and the history fill count that follow. They do assume that downstream sees `out_data` only through the handshake, and that reset is held low across at least one edge before traffic. The stimulus changes all inputs on falling edges only. It holds reset for several cycles. It mixes gapped and back-to-back offers with random back-pressure, and it feeds garbage on the data pins while `in_valid` is low. That keeps every input transition clear of the sampling edge.

// File: rtl/fir2p_pkg.sv
package fir2p_pkg;
  // Fold the outer coefficient product into one base coefficient.
  // The arithmetic shift gives floor rounding.
  function automatic longint pre_scale(input longint base_c, input longint outer_prod, input int shift);
    longint full;
    full = base_c * outer_prod;
    return full >>> shift;
  endfunction
endpackage

// File: rtl/fir2p_delay_line.sv
module fir2p_delay_line #(
  parameter int DATA_W = 12,
  parameter int TAPS   = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     shift_en,
  input  logic [DATA_W-1:0]        din,
  output logic [TAPS*DATA_W-1:0]   taps
);
  assign taps[DATA_W-1:0] = din;

  if (TAPS > 1) begin : g_regs
    logic [DATA_W-1:0] stage [TAPS-1];

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        for (int i = 0; i < TAPS-1; i++) stage[i] <= '0;
      end else if (shift_en) begin
        stage[0] <= din;
        for (int i = 1; i < TAPS-1; i++) stage[i] <= stage[i-1];
      end
    end

    for (genvar i = 1; i < TAPS; i++) begin : g_out
      assign taps[i*DATA_W +: DATA_W] = stage[i-1];
    end
  end
endmodule

// File: rtl/fir2p_tap_mult.sv
module fir2p_tap_mult #(
  parameter int DATA_W = 12,
  parameter int W_W    = 16,
  parameter int OUT_W  = 32,
  parameter logic signed [W_W-1:0] WEIGHT = '0
) (
  input  logic signed [DATA_W-1:0] sample,
  output logic signed [OUT_W-1:0]  product
);
  localparam logic signed [OUT_W-1:0] WX = OUT_W'(WEIGHT);
  logic signed [OUT_W-1:0] sx;
  assign sx      = OUT_W'(sample);
  assign product = sx * WX;
endmodule

// File: rtl/fir2p_tap_stage.sv
module fir2p_tap_stage #(
  parameter int DATA_W     = 12,
  parameter int W_W        = 16,
  parameter int OUT_W      = 32,
  parameter int FRAC_W     = 10,
  parameter int NTAPS      = 5,
  parameter int OUTER_DIMS = 2,
  parameter logic [OUTER_DIMS-1:0] OUTER_PARITY = 2'b10,
  parameter int BASE_COEF [NTAPS] = '{-77, 280, 640, 232, -53}
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  output logic                     in_ready,
  input  logic signed [DATA_W-1:0] in_even,
  input  logic signed [DATA_W-1:0] in_odd,
  output logic                     out_valid,
  input  logic                     out_ready,
  output logic signed [OUT_W-1:0]  out_data
);
  localparam int NE     = (NTAPS + 1) / 2;  // even-index taps, odd stream
  localparam int NO     = NTAPS / 2;        // odd-index taps, even stream
  localparam int NEED   = NE - 1;           // pairs of history before output
  localparam int FILL_W = $clog2(NEED + 2);

  function automatic longint outer_prod();
    longint p = 1;
    for (int d = 0; d < OUTER_DIMS; d++) p = p * longint'(BASE_COEF[OUTER_PARITY[d]]);
    return p;
  endfunction

  logic                    accept;
  logic [FILL_W-1:0]       fill_cnt;
  logic [NO*DATA_W-1:0]    ev_taps;
  logic [NE*DATA_W-1:0]    od_taps;
  logic signed [OUT_W-1:0] prod [NTAPS];
  logic signed [OUT_W-1:0] sum;

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  fir2p_delay_line #(.DATA_W(DATA_W), .TAPS(NO)) u_even_line (
    .clk(clk), .rst_n(rst_n), .shift_en(accept), .din(in_even), .taps(ev_taps)
  );
  fir2p_delay_line #(.DATA_W(DATA_W), .TAPS(NE)) u_odd_line (
    .clk(clk), .rst_n(rst_n), .shift_en(accept), .din(in_odd), .taps(od_taps)
  );

  for (genvar k = 0; k < NTAPS; k++) begin : g_tap
    localparam longint WL = fir2p_pkg::pre_scale(longint'(BASE_COEF[k]), outer_prod(),
                                                 FRAC_W * OUTER_DIMS);
    localparam logic signed [W_W-1:0] WQ = W_W'(WL);
    logic signed [DATA_W-1:0] smp;
    if (k % 2 == 1) begin : g_odd_idx
      assign smp = $signed(ev_taps[((k-1)/2)*DATA_W +: DATA_W]);
    end else begin : g_even_idx
      assign smp = $signed(od_taps[(k/2)*DATA_W +: DATA_W]);
    end
    fir2p_tap_mult #(.DATA_W(DATA_W), .W_W(W_W), .OUT_W(OUT_W), .WEIGHT(WQ)) u_mult (
      .sample(smp), .product(prod[k])
    );
  end

  always_comb begin
    sum = '0;
    for (int k = 0; k < NTAPS; k++) sum = sum + prod[k];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fill_cnt  <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      if (accept && fill_cnt != FILL_W'(NEED)) fill_cnt <= fill_cnt + 1'b1;
      if (in_ready) out_valid <= accept && (fill_cnt == FILL_W'(NEED));
      if (accept) out_data <= sum;
    end
  end

  // R6
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data));
  // R6
  ready_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready);
  // R4
  fill_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill_cnt <= FILL_W'(NEED));
  // R4
  rise_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(accept));
  // R5
  latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept && fill_cnt == FILL_W'(NEED) |=> out_valid);
endmodule

// File: tb/fir2p_tap_stage_test.sv
module fir2p_tap_stage_test;
  localparam int DW = 12;
  localparam int OW = 32;
  localparam int NT = 5;
  localparam int C [NT] = '{-77, 280, 640, 232, -53};

  logic clk = 0, rst_n = 0;
  logic in_valid = 0, out_ready = 0;
  logic signed [DW-1:0] in_even = '0, in_odd = '0;
  logic in_ready, out_valid;
  logic signed [OW-1:0] out_data;

  int errors = 0, checks = 0;
  int accepted = 0, outputs = 0;
  string cur_req = "R3";
  longint w [NT];
  int ev_h [$];
  int od_h [$];
  logic signed [OW-1:0] exp_q [$];
  bit prev_stall = 0;
  logic signed [OW-1:0] prev_data;

  always #5 clk = ~clk;

  fir2p_tap_stage #(.DATA_W(DW), .W_W(16), .OUT_W(OW), .FRAC_W(10), .NTAPS(NT),
                    .OUTER_DIMS(2), .OUTER_PARITY(2'b10), .BASE_COEF(C)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_even(in_even), .in_odd(in_odd), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data)
  );

  task automatic check(input string req, input bit ok, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic signed [OW-1:0] model(input int n);
    longint s = 0;
    for (int k = 0; k < NT; k++) begin
      if (k % 2 == 1) s += w[k] * longint'(ev_h[n - (k-1)/2]);
      else            s += w[k] * longint'(od_h[n - k/2]);
    end
    return OW'(s);
  endfunction

  // driver: one cycle of stimulus, scoreboard push on acceptance
  task automatic drive(input bit v, input int e, input int o, input bit rdy);
    @(negedge clk);
    in_valid = v; in_even = DW'(e); in_odd = DW'(o); out_ready = rdy;
    #1;
    if (v && in_ready) begin
      ev_h.push_back(int'(in_even));
      od_h.push_back(int'(in_odd));
      if (accepted >= 2) exp_q.push_back(model(accepted));
      accepted++;
    end
  endtask

  // monitor
  always begin
    @(negedge clk);
    #2;
    if (rst_n) begin
      if (prev_stall) // R6
        check("R6", out_valid && out_data == prev_data, out_data, prev_data);
      if (out_valid && out_ready) begin
        outputs++;
        if (exp_q.size() == 0) check("R4", 0, out_data, 0);
        else begin
          logic signed [OW-1:0] e;
          e = exp_q.pop_front();
          check(cur_req, out_data == e, out_data, e);
        end
      end
      prev_stall = out_valid && !out_ready;
      prev_data  = out_data;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    check("watchdog", 0, 0, 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    longint p;
    p = longint'(C[0]) * longint'(C[1]);  // parity bit0=0 -> h0, bit1=1 -> h1
    for (int k = 0; k < NT; k++) w[k] = (longint'(C[k]) * p) >>> 20;

    repeat (4) @(negedge clk);
    // R1
    check("R1", out_valid == 0, out_valid, 0);
    check("R1", in_ready == 1, in_ready, 1);
    @(negedge clk); rst_n = 1;

    // R4 warm-up: two accepted pairs give nothing
    drive(1, 5, 7, 1);
    drive(1, -3, 9, 1);
    @(negedge clk); #1;
    check("R4", out_valid == 0, out_valid, 0);
    in_valid = 0;

    // R2 impulse on even stream, then on odd stream
    cur_req = "R2";
    drive(1, 1000, 0, 1);
    for (int i = 0; i < 4; i++) drive(1, 0, 0, 1);
    drive(1, 0, 1000, 1);
    for (int i = 0; i < 4; i++) drive(1, 0, 0, 1);
    drive(0, 0, 0, 1);

    // R3 random back-to-back
    cur_req = "R3";
    for (int i = 0; i < 30; i++) drive(1, $urandom_range(4095) - 2048, $urandom_range(4095) - 2048, 1);
    drive(0, 0, 0, 1);

    // R7 gaps with garbage on data pins
    cur_req = "R7";
    for (int i = 0; i < 40; i++)
      drive($urandom_range(1), $urandom_range(4095) - 2048, $urandom_range(4095) - 2048, 1);
    drive(0, 0, 0, 1);

    // R6 random back-pressure
    cur_req = "R6";
    for (int i = 0; i < 60; i++)
      drive($urandom_range(1), $urandom_range(4095) - 2048, $urandom_range(4095) - 2048, $urandom_range(1));
    for (int i = 0; i < 4; i++) drive(0, 0, 0, 1);

    // R8 full-scale values
    cur_req = "R8";
    for (int i = 0; i < 6; i++) drive(1, 2047, -2048, 1);
    for (int i = 0; i < 6; i++) drive(1, -2048, 2047, 1);
    for (int i = 0; i < 3; i++) drive(0, 0, 0, 1);

    // R5 single pair into an empty output register
    cur_req = "R5";
    check("R5", out_valid == 0, out_valid, 0);
    drive(1, 321, -654, 1);
    @(negedge clk); #1;
    check("R5", out_valid == 1, out_valid, 1);
    in_valid = 0;
    for (int i = 0; i < 3; i++) drive(0, 0, 0, 1);

    // R4 totals
    check("R4", exp_q.size() == 0, exp_q.size(), 0);
    check("R4", outputs == accepted - 2, outputs, accepted - 2);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule